// File: doc/BRIEF.md
# Pipelined Burst SRAM with Byte-Lane Writes

This block is a cycle-accurate synchronous static memory that sits behind a memory controller or a processor bus. An access starts when one of two address strobes is seen on a rising clock edge. The processor-side strobe always starts a read. The controller-side strobe starts a read or a write, depending on the write controls. Later cycles may continue the access as a 4-word burst. In each of those cycles a burst-advance input either steps the two low address bits, wrapping inside an aligned 4-word block, or holds them. Writes can cover the whole word through a global write control, or only chosen byte lanes through a byte-write enable and one strobe per lane. Each lane carries an optional parity bit that is written together with its byte.

Read data goes through an output register. The data bus is split into an input vector, a registered output vector and a drive enable. A low drive enable stands for a bus at high impedance. Deselecting the device releases the bus one clock later. While the sleep input is high, every command is ignored and the bus is released. The stored data and the burst position are kept.

Top module: `pbsram_core`

## Requirements
- R1: Byte lane g is bits [g*LW +: LW] of the data vectors, where LW = 8 + PAR_EN and the parity bit is the top bit of the lane. A written lane takes the whole LW-bit slice from `dq_i`, sampled on the edge that issues the write. Lanes that are not written keep their old contents.
- R2: When `all_wr_n_i` is low during an access cycle, every lane is written, whatever `byte_wr_en_n_i` and `lane_wr_n_i` hold.
- R3: When `all_wr_n_i` is high, a write happens only if `byte_wr_en_n_i` is low, and it affects exactly the lanes whose `lane_wr_n_i` bit is low. Any subset of lanes may be chosen. With `byte_wr_en_n_i` high the cycle is a read, and no lane changes.
- R4: The device is selected when `sel_n_i`=0, `sel_hi_i`=1 and `sel_aux_n_i`=0. If `ads_cpu_n_i`=0 and `sel_n_i`=0 at an edge, that strobe takes priority and starts a read of `addr_i`, and the write controls are ignored on that edge. Otherwise `ads_ctl_n_i`=0 starts a read or a write of `addr_i`. Either strobe may start consecutive reads.
- R5: During an active burst, an edge with both strobes high continues the access. With `adv_n_i`=0 the low two address bits are incremented modulo 4. With `adv_n_i`=1 the same address is reused. The upper address bits never change. The write controls choose read or write in every continuation cycle.
- R6: Data for a read issued at edge t sits in the output register from edge t+1 to edge t+2. During that cycle `dq_oe_o` is high exactly when `rd_oe_n_i` is low and `sleep_i` is low.
- R7: A strobe that starts an access while the device is not selected is a deselect. It ends the burst, so later continuation cycles do nothing, and `dq_oe_o` is low from the second edge after the deselect edge onward.
- R8: `ads_cpu_n_i` has no effect while `sel_n_i` is high. `ads_ctl_n_i` is evaluated in every cycle.
- R9: While `sleep_i` is high, no read, write, start, deselect or burst step takes place and `dq_oe_o` is low. Memory contents and the burst position are kept for use after wake-up.
- R10: After a synchronous reset, `dq_oe_o` is low and no burst is active. Memory contents are not defined by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | AW | Word address sampled on a start edge |
| sel_n_i | input | 1 | Primary enable, active low; also qualifies the processor strobe |
| sel_hi_i | input | 1 | Secondary enable, active high |
| sel_aux_n_i | input | 1 | Secondary enable, active low |
| ads_cpu_n_i | input | 1 | Processor-side address strobe, active low |
| ads_ctl_n_i | input | 1 | Controller-side address strobe, active low |
| adv_n_i | input | 1 | Burst advance, active low |
| rd_oe_n_i | input | 1 | Output enable, active low |
| all_wr_n_i | input | 1 | Global write, active low |
| byte_wr_en_n_i | input | 1 | Byte-write enable, active low |
| lane_wr_n_i | input | LANES | Per-lane write strobes, active low |
| dq_i | input | LANES*LW | Write data |
| dq_o | output | LANES*LW | Registered read data |
| dq_oe_o | output | 1 | Bus drive enable; low means high impedance |
| sleep_i | input | 1 | Sleep request, active high |

## Verification
A wrong burst counter or a lost base address shows up as wrong read data on the cycle after the affected access. A wrong lane mask shows up only when that word is read back. A stale valid bit in the read pipeline shows up within two edges, as a bus that is driven after a deselect or during sleep, or as a missing drive one edge after a read. The reference model follows every access, so each of these faults is caught on the first cycle in which it reaches the ports.

// File: rtl/pbsram_pkg.sv
package pbsram_pkg;
  // Kind of access decoded for the current clock edge.
  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_DESEL = 2'd1,
    CMD_START = 2'd2,
    CMD_CONT  = 2'd3
  } cmd_e;
endpackage

// File: rtl/sbs_cmd_decode.sv
module sbs_cmd_decode
  import pbsram_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             sleep_i,
  input  logic             sel_n_i,
  input  logic             sel_hi_i,
  input  logic             sel_aux_n_i,
  input  logic             ads_cpu_n_i,
  input  logic             ads_ctl_n_i,
  input  logic             adv_n_i,
  input  logic             all_wr_n_i,
  input  logic             byte_wr_en_n_i,
  input  logic [LANES-1:0] lane_wr_n_i,
  input  logic             burst_act_i,
  output cmd_e             cmd_o,
  output logic             step_o,
  output logic             rd_en_o,
  output logic [LANES-1:0] wr_mask_o
);

  logic             selected;
  logic [LANES-1:0] req_mask;

  assign selected = !sel_n_i && sel_hi_i && !sel_aux_n_i;

  // The global write overrides the byte path.
  always_comb begin
    if (!all_wr_n_i)          req_mask = '1;
    else if (!byte_wr_en_n_i) req_mask = ~lane_wr_n_i;
    else                      req_mask = '0;
  end

  // Priority: sleep, processor strobe (primary enable low), controller
  // strobe, burst continuation.
  always_comb begin
    cmd_o     = CMD_IDLE;
    step_o    = 1'b0;
    rd_en_o   = 1'b0;
    wr_mask_o = '0;
    if (!sleep_i) begin
      if (!ads_cpu_n_i && !sel_n_i) begin
        cmd_o   = selected ? CMD_START : CMD_DESEL;
        rd_en_o = selected;
      end else if (!ads_ctl_n_i) begin
        cmd_o     = selected ? CMD_START : CMD_DESEL;
        wr_mask_o = selected ? req_mask : '0;
        rd_en_o   = selected && (req_mask == '0);
      end else if (burst_act_i) begin
        cmd_o     = CMD_CONT;
        step_o    = !adv_n_i;
        wr_mask_o = req_mask;
        rd_en_o   = (req_mask == '0);
      end
    end
  end

endmodule

// File: rtl/sbs_burst_addr.sv
module sbs_burst_addr
  import pbsram_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  cmd_e          cmd_i,
  input  logic          step_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] eff_addr_o,
  output logic [AW-1:0] cur_addr_o,
  output logic          burst_act_o
);

  localparam int HI_W = AW - 2;

  logic [HI_W-1:0] hi_q;
  logic [1:0]      cnt_q;
  logic            act_q;
  logic [1:0]      cnt_nxt;

  assign cnt_nxt = step_i ? (cnt_q + 2'd1) : cnt_q;

  always_comb begin
    case (cmd_i)
      CMD_START: eff_addr_o = addr_i;
      CMD_CONT:  eff_addr_o = {hi_q, cnt_nxt};
      default:   eff_addr_o = {hi_q, cnt_q};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= 1'b0;
      hi_q  <= '0;
      cnt_q <= 2'd0;
    end else begin
      case (cmd_i)
        CMD_START: begin
          act_q <= 1'b1;
          hi_q  <= addr_i[AW-1:2];
          cnt_q <= addr_i[1:0];
        end
        CMD_CONT:  cnt_q <= cnt_nxt;
        CMD_DESEL: act_q <= 1'b0;
        default:   act_q <= act_q;
      endcase
    end
  end

  assign cur_addr_o  = {hi_q, cnt_q};
  assign burst_act_o = act_q;

endmodule

// File: rtl/sbs_lane_mem.sv
module sbs_lane_mem #(
  parameter int AW = 10,
  parameter int LW = 9
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [LW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [LW-1:0] rdata_o
);

  localparam int DEPTH = 1 << AW;

  logic [LW-1:0] mem [DEPTH];

  // Simple dual-port, read-first: suited to block RAM inference.
  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end

endmodule

// File: rtl/pbsram_core.sv
module pbsram_core
  import pbsram_pkg::*;
#(
  parameter int AW     = 10,
  parameter int LANES  = 4,
  parameter int PAR_EN = 1
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [AW-1:0]                  addr_i,
  input  logic                           sel_n_i,
  input  logic                           sel_hi_i,
  input  logic                           sel_aux_n_i,
  input  logic                           ads_cpu_n_i,
  input  logic                           ads_ctl_n_i,
  input  logic                           adv_n_i,
  input  logic                           rd_oe_n_i,
  input  logic                           all_wr_n_i,
  input  logic                           byte_wr_en_n_i,
  input  logic [LANES-1:0]               lane_wr_n_i,
  input  logic [LANES*(8+PAR_EN)-1:0]    dq_i,
  output logic [LANES*(8+PAR_EN)-1:0]    dq_o,
  output logic                           dq_oe_o,
  input  logic                           sleep_i
);

  localparam int LW = 8 + PAR_EN;

  cmd_e             cmd;
  logic             step;
  logic             rd_en;
  logic [LANES-1:0] wr_mask;
  logic             burst_act;
  logic [AW-1:0]    eff_addr;
  logic [AW-1:0]    cur_addr;

  logic             rd_v_q;
  logic [AW-1:0]    rd_addr_q;
  logic             out_v_q;

  sbs_cmd_decode #(.LANES(LANES)) u_dec (
    .sleep_i        (sleep_i),
    .sel_n_i        (sel_n_i),
    .sel_hi_i       (sel_hi_i),
    .sel_aux_n_i    (sel_aux_n_i),
    .ads_cpu_n_i    (ads_cpu_n_i),
    .ads_ctl_n_i    (ads_ctl_n_i),
    .adv_n_i        (adv_n_i),
    .all_wr_n_i     (all_wr_n_i),
    .byte_wr_en_n_i (byte_wr_en_n_i),
    .lane_wr_n_i    (lane_wr_n_i),
    .burst_act_i    (burst_act),
    .cmd_o          (cmd),
    .step_o         (step),
    .rd_en_o        (rd_en),
    .wr_mask_o      (wr_mask)
  );

  sbs_burst_addr #(.AW(AW)) u_burst (
    .clk         (clk),
    .rst         (rst),
    .cmd_i       (cmd),
    .step_i      (step),
    .addr_i      (addr_i),
    .eff_addr_o  (eff_addr),
    .cur_addr_o  (cur_addr),
    .burst_act_o (burst_act)
  );

  // Read pipeline: the address is registered on the issuing edge; the lane
  // memories register the data on the following edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_v_q    <= 1'b0;
      out_v_q   <= 1'b0;
      rd_addr_q <= '0;
    end else begin
      rd_v_q    <= rd_en;
      out_v_q   <= rd_v_q;
      rd_addr_q <= eff_addr;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sbs_lane_mem #(.AW(AW), .LW(LW)) u_mem (
      .clk     (clk),
      .we_i    (wr_mask[g]),
      .waddr_i (eff_addr),
      .wdata_i (dq_i[g*LW +: LW]),
      .raddr_i (rd_addr_q),
      .rdata_o (dq_o[g*LW +: LW])
    );
  end

  assign dq_oe_o = out_v_q && !rd_oe_n_i && !sleep_i;

endmodule

// File: rtl/pbsram_core_chk.sv
module pbsram_core_chk
  import pbsram_pkg::*;
#(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] addr_i,
  input logic          ads_cpu_n_i,
  input logic          ads_ctl_n_i,
  input logic          sel_n_i,
  input logic          rd_oe_n_i,
  input logic          sleep_i,
  input logic          dq_oe_o,
  input cmd_e          cmd,
  input logic          step,
  input logic          rd_en,
  input logic          burst_act,
  input logic [AW-1:0] cur_addr
);

  a_r4_start_loads: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_START) |=> (burst_act && cur_addr == $past(addr_i)));

  a_r5_step_wraps: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_CONT && step) |=>
      (cur_addr[1:0] == $past(cur_addr[1:0]) + 2'd1 &&
       cur_addr[AW-1:2] == $past(cur_addr[AW-1:2])));

  a_r5_hold_addr: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_CONT && !step) |=> $stable(cur_addr));

  a_r6_drive_after_read: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> ##1 (rd_oe_n_i || sleep_i || dq_oe_o));

  a_r7_release: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_DESEL) |=> ##1 !dq_oe_o);

  a_r8_cpu_ignored: assert property (@(posedge clk) disable iff (rst)
    (!ads_cpu_n_i && sel_n_i && ads_ctl_n_i && !burst_act) |=> !burst_act);

  a_r9_sleep_quiet: assert property (@(posedge clk) disable iff (rst)
    sleep_i |=> ##1 !dq_oe_o);

  a_r9_sleep_keeps: assert property (@(posedge clk) disable iff (rst)
    sleep_i |=> ($stable(cur_addr) && $stable(burst_act)));

endmodule

bind pbsram_core pbsram_core_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .addr_i      (addr_i),
  .ads_cpu_n_i (ads_cpu_n_i),
  .ads_ctl_n_i (ads_ctl_n_i),
  .sel_n_i     (sel_n_i),
  .rd_oe_n_i   (rd_oe_n_i),
  .sleep_i     (sleep_i),
  .dq_oe_o     (dq_oe_o),
  .cmd         (cmd),
  .step        (step),
  .rd_en       (rd_en),
  .burst_act   (burst_act),
  .cur_addr    (cur_addr)
);

// File: tb/pbsram_core_tb_top.sv
module pbsram_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int LANES = 4;
  localparam int LW = 9;
  localparam int DW = LANES * LW;
  localparam int DEPTH = 1 << AW;

  logic             clk = 1'b0;
  logic             rst;
  logic [AW-1:0]    addr;
  logic             sel_n, sel_hi, sel_aux_n, cpu_n, ctl_n, adv_n, oe_n;
  logic             gw_n, bwe_n, sleep;
  logic [LANES-1:0] lw_n;
  logic [DW-1:0]    din;
  logic [DW-1:0]    dout;
  logic             doe;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // Reference model state
  logic [DW-1:0] m_mem [DEPTH];
  bit            m_act = 0;
  int            m_cur = 0;
  bit            m_rv = 0;
  int            m_raddr = 0;
  bit            m_ov = 0;
  logic [DW-1:0] m_out = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pbsram_core #(.AW(AW), .LANES(LANES), .PAR_EN(1)) dut_i (
    .clk(clk), .rst(rst), .addr_i(addr), .sel_n_i(sel_n), .sel_hi_i(sel_hi),
    .sel_aux_n_i(sel_aux_n), .ads_cpu_n_i(cpu_n), .ads_ctl_n_i(ctl_n),
    .adv_n_i(adv_n), .rd_oe_n_i(oe_n), .all_wr_n_i(gw_n),
    .byte_wr_en_n_i(bwe_n), .lane_wr_n_i(lw_n), .dq_i(din), .dq_o(dout),
    .dq_oe_o(doe), .sleep_i(sleep)
  );

  task automatic chk(input string tag, input bit ok, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle_in();
    cpu_n = 1; ctl_n = 1; adv_n = 1; gw_n = 1; bwe_n = 1; lw_n = '1;
    sel_n = 0; sel_hi = 1; sel_aux_n = 0; sleep = 0; oe_n = 0;
  endtask

  task automatic rand_data();
    logic [63:0] r;
    r = {$urandom(), $urandom()};
    din = r[DW-1:0];
  endtask

  task automatic model_step();
    logic [DW-1:0]    nd;
    bit               nv;
    logic [LANES-1:0] msk;
    bit sel, rdi, wri;
    int ea;
    nd = m_mem[m_raddr];
    nv = m_rv;
    rdi = 0; wri = 0; ea = 0;
    if (rst) begin
      m_act = 0; m_rv = 0; m_ov = 0;
      return;
    end
    sel = !sel_n && sel_hi && !sel_aux_n;
    msk = !gw_n ? '1 : (!bwe_n ? ~lw_n : '0);
    if (!sleep) begin
      if (!cpu_n && !sel_n) begin
        if (sel) begin m_act = 1; m_cur = int'(addr); ea = m_cur; rdi = 1; end
        else m_act = 0;
      end else if (!ctl_n) begin
        if (sel) begin m_act = 1; m_cur = int'(addr); ea = m_cur; wri = 1; end
        else m_act = 0;
      end else if (m_act) begin
        if (!adv_n) m_cur = (m_cur & ~3) | ((m_cur + 1) & 3);
        ea = m_cur; wri = 1;
      end
    end
    if (wri) begin
      if (msk == '0) rdi = 1;
      else for (int l = 0; l < LANES; l++)
        if (msk[l]) m_mem[ea][l*LW +: LW] = din[l*LW +: LW];
    end
    m_rv = rdi;
    if (rdi) m_raddr = ea;
    m_ov = nv;
    m_out = nd;
  endtask

  // Compare the current cycle, then take one edge.
  task automatic tick(input string tag);
    bit exp_oe;
    #1;
    exp_oe = m_ov && !oe_n && !sleep;
    chk({tag, " drive"}, doe == exp_oe, 64'(doe), 64'(exp_oe));
    if (exp_oe) chk({tag, " data"}, dout == m_out, 64'(dout), 64'(m_out));
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    addr = '0; din = '0; rst = 1; idle_in();
    @(negedge clk);
    repeat (3) tick("R10");
    rst = 0;
    tick("R10");
    chk("R10 idle after reset", doe == 1'b0, 64'(doe), 64'd0);

    // R2: fill the whole array with 4-word bursts using the global write
    for (int b = 0; b < DEPTH; b += 4) begin
      ctl_n = 0; gw_n = 0; bwe_n = 1; lw_n = 4'b0101; addr = AW'(b); rand_data();
      tick("R2");
      ctl_n = 1;
      for (int i = 0; i < 3; i++) begin adv_n = 0; rand_data(); tick("R2"); end
      idle_in();
    end

    // R6: latency, then output enable high during the data cycle
    ctl_n = 0; addr = 10'd5; tick("R6"); idle_in();
    tick("R6"); tick("R6");
    ctl_n = 0; addr = 10'd6; tick("R6"); idle_in(); oe_n = 1;
    tick("R6");
    chk("R6 undriven with oe high", doe == 1'b0, 64'(doe), 64'd0);
    oe_n = 0; tick("R6");

    // R4: back-to-back reads from alternating strobes; processor priority
    for (int i = 8; i < 16; i++) begin
      if (i % 2 == 0) cpu_n = 0; else ctl_n = 0;
      addr = AW'(i); tick("R4"); idle_in();
    end
    cpu_n = 0; ctl_n = 0; gw_n = 0; addr = 10'd40; rand_data(); tick("R4");
    idle_in(); ctl_n = 0; addr = 10'd40; tick("R4"); idle_in();
    tick("R4"); tick("R4");

    // R1/R3: byte-lane writes, then a disabled byte write, then read back
    ctl_n = 0; bwe_n = 0; lw_n = 4'b1010; addr = 10'd20; rand_data(); tick("R1");
    idle_in(); ctl_n = 0; bwe_n = 1; lw_n = 4'b0000; addr = 10'd20; rand_data();
    tick("R3"); idle_in();
    ctl_n = 0; bwe_n = 0; lw_n = 4'b0111; addr = 10'd21; rand_data(); tick("R3");
    idle_in(); ctl_n = 0; gw_n = 0; bwe_n = 1; lw_n = 4'b1111; addr = 10'd22;
    rand_data(); tick("R2"); idle_in();
    for (int i = 20; i < 23; i++) begin ctl_n = 0; addr = AW'(i); tick("R1"); idle_in(); end
    tick("R1"); tick("R1");

    // R5: read burst from low bits 2, wrap, then suspend, then burst write
    ctl_n = 0; addr = 10'd30; tick("R5"); idle_in();
    for (int i = 0; i < 5; i++) begin adv_n = 0; tick("R5"); end
    adv_n = 1; tick("R5"); tick("R5");
    ctl_n = 0; bwe_n = 0; lw_n = 4'b1100; addr = 10'd61; rand_data(); tick("R5");
    idle_in();
    for (int i = 0; i < 4; i++) begin adv_n = 0; bwe_n = 0; lw_n = 4'b0011; rand_data(); tick("R5"); end
    idle_in(); ctl_n = 0; addr = 10'd60; tick("R5"); idle_in();
    for (int i = 0; i < 4; i++) begin adv_n = 0; tick("R5"); end
    idle_in();

    // R7: deselect in the middle of a burst, then continuations do nothing
    ctl_n = 0; addr = 10'd100; tick("R7"); idle_in();
    ctl_n = 0; sel_aux_n = 1; tick("R7"); idle_in();
    tick("R7");
    for (int i = 0; i < 3; i++) begin
      adv_n = 0; gw_n = 0; rand_data(); tick("R7");
      chk("R7 released after deselect", doe == 1'b0, 64'(doe), 64'd0);
    end
    idle_in(); ctl_n = 0; addr = 10'd100; tick("R7"); idle_in(); tick("R7"); tick("R7");

    // R8: processor strobe ignored with primary enable high
    ctl_n = 0; sel_aux_n = 1; tick("R8"); idle_in();
    sel_n = 1; cpu_n = 0; addr = 10'd7; tick("R8"); idle_in();
    tick("R8");
    chk("R8 no read from ignored strobe", doe == 1'b0, 64'(doe), 64'd0);
    sel_n = 1; ctl_n = 0; addr = 10'd8; tick("R8"); idle_in();
    ctl_n = 0; addr = 10'd9; tick("R8"); idle_in();
    sel_n = 1; cpu_n = 0; adv_n = 0; tick("R8"); idle_in(); tick("R8"); tick("R8");

    // R9: sleep in the middle of a burst; commands ignored, state kept
    ctl_n = 0; addr = 10'd200; tick("R9"); idle_in();
    sleep = 1; tick("R9");
    for (int i = 0; i < 3; i++) begin
      sleep = 1; ctl_n = 0; gw_n = 0; addr = AW'(300 + i); adv_n = 0; rand_data();
      tick("R9");
      chk("R9 bus released in sleep", doe == 1'b0, 64'(doe), 64'd0);
    end
    idle_in(); adv_n = 0; tick("R9"); tick("R9"); idle_in();
    for (int i = 0; i < 3; i++) begin ctl_n = 0; addr = AW'(300 + i); tick("R9"); idle_in(); end
    tick("R9"); tick("R9");

    // R3: mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      idle_in();
      addr = AW'($urandom_range(0, DEPTH - 1));
      rand_data();
      cpu_n = (r < 15) ? 1'b0 : 1'b1;
      ctl_n = (r >= 10 && r < 35) ? 1'b0 : 1'b1;
      adv_n = $urandom_range(0, 1) == 0;
      gw_n = $urandom_range(0, 5) != 0;
      bwe_n = $urandom_range(0, 2) == 0;
      lw_n = 4'($urandom_range(0, 15));
      sel_n = $urandom_range(0, 9) == 0;
      sel_aux_n = $urandom_range(0, 11) == 0;
      oe_n = $urandom_range(0, 7) == 0;
      sleep = $urandom_range(0, 19) == 0;
      tick("R3");
    end
    idle_in(); tick("R3"); tick("R3");

    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule